// File: doc/BRIEF.md
# Multi-Slot Module Interrupt Aggregator

This block merges the interrupt lines of four plug-in module slots into a single host interrupt. Each slot drives two lines. Each line can be enabled or disabled, and each can run in level mode or edge mode. A slot also has a timeout input. Pending events are recorded in one 16-bit status register. The host reads and writes that register and the four per-slot control registers through a simple 16-bit register port. It can also acknowledge a level-mode line with a read-style strobe into that slot's interrupt-acknowledge space.

Level-mode pending bits hold the host interrupt high until none remain. An edge-mode event inverts the host interrupt for exactly one cycle and does not hold it.

Top module: `slot_irq_aggregator`

## Requirements
- R1: After reset every slot control register reads 0x0000, the status register reads 0x0000, and irq_o is 0.
- R2: A register write to byte offset 0x02 + 2*slot stores wdata_i[7:0] as that slot's control byte. A read of that offset returns the byte zero-extended to 16 bits. Control bit 7 enables line 1 and bit 6 enables line 0. Bit 5 selects edge mode for line 1 and bit 4 selects edge mode for line 0. Bits 3..0 are stored only.
- R3: Offsets 0x00 (revision) and 0x0A (reset) and any unmapped offset read as 0x0000. Writes to these offsets change no control or status bit.
- R4: While a line's enable bit is 0, changes on that line leave its status bit and irq_o unchanged.
- R5: For an enabled line, a rising edge sets status bit (2*slot + line) on the clock edge that samples it, and a falling edge clears that bit.
- R6: irq_o is 1 while any status bit whose line is in level mode is set. irq_o returns to 0 when no such bit remains, unless an edge pulse is active.
- R7: When an enabled edge-mode line rises and its status bit was clear, irq_o is inverted for exactly one cycle and then returns to the level that R6 gives.
- R8: Writing 1 to a status bit in positions 7..0 or 15..12 clears that bit. Writing 0 leaves it unchanged. Bits 11..8 always read 0 and writes to them have no effect.
- R9: An acknowledge strobe for a slot at offset 0 clears line 0 of that slot, and at offset 2 clears line 1, but only when that line is in level mode. In edge mode, or at any other offset, the strobe has no effect.
- R10: A high tmo_i[slot] sets status bit 12 + slot. If a clear of that bit lands in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 8 | Interrupt lines; bit 2*slot+line |
| tmo_i | input | 4 | Per-slot timeout event |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid the cycle after a read strobe |
| ack_req_i | input | 1 | Interrupt-acknowledge strobe |
| ack_slot_i | input | 2 | Slot being acknowledged |
| ack_ofs_i | input | 6 | Offset inside the slot's acknowledge space |
| irq_o | output | 1 | Host interrupt |

## Verification
A pending bit that is stuck or wrongly cleared shows up in two places: the next status read, and irq_o one clock after the line edge. A wrong edge or level selection shows up at once as an interrupt that is held instead of pulsed, or pulsed instead of held. A control byte stored in the wrong slot shows up on readback. It also shows up as a line that is ignored, or one that is wrongly accepted, on the following line edge. The directed tests sample irq_o on each cycle around every event, so a pulse that is one cycle too long or one cycle late is caught.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  localparam int unsigned OFS_REV   = 'h00;
  localparam int unsigned OFS_CTRL0 = 'h02;
  localparam int unsigned OFS_RST   = 'h0A;
  localparam int unsigned OFS_STAT  = 'h0C;

  typedef struct packed {
    logic [1:0] en;       // [7:6]
    logic [1:0] edge_m;   // [5:4]
    logic       err_ie;
    logic       tmo_ie;
    logic       recover;
    logic       clk_rate;
  } slot_ctrl_t;
endpackage

// File: rtl/aggr_ctrl_regs.sv
module aggr_ctrl_regs
  import aggr_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned AW    = 8,
  localparam int unsigned LINES = 2 * NSLOT
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [7:0]            wdata_i,
  output logic [NSLOT-1:0][7:0] ctrl_o,
  output logic [LINES-1:0]      en_o,
  output logic [LINES-1:0]      edge_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [AW-1:0] MY_OFS = AW'(OFS_CTRL0 + 2 * s);
    slot_ctrl_t ctrl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        ctrl_q <= '0;
      else if (wr_i && addr_i == MY_OFS)  ctrl_q <= slot_ctrl_t'(wdata_i);
    end

    assign ctrl_o[s]        = ctrl_q;
    assign en_o[2*s +: 2]   = ctrl_q.en;
    assign edge_o[2*s +: 2] = ctrl_q.edge_m;
  end
endmodule

// File: rtl/aggr_pending.sv
module aggr_pending #(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned LINES   = 2 * NSLOT,
  localparam int unsigned TMO_LSB = LINES + NSLOT,
  localparam int unsigned STAT_W  = TMO_LSB + NSLOT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  line_i,
  input  logic [NSLOT-1:0]  tmo_i,
  input  logic [LINES-1:0]  en_i,
  input  logic [LINES-1:0]  edge_i,
  input  logic [STAT_W-1:0] w1c_i,
  input  logic [LINES-1:0]  ack_i,
  output logic [STAT_W-1:0] status_o,
  output logic              edge_new_o
);
  logic [LINES-1:0] line_q, pend_q, pend_d;
  logic [LINES-1:0] rise, fall, set_v, clr_v;
  logic [NSLOT-1:0] tmo_q, tmo_d;

  always_comb begin
    rise   = line_i & ~line_q;
    fall   = ~line_i & line_q;
    set_v  = en_i & rise;
    // acknowledge only reaches level-mode lines
    clr_v  = (en_i & fall) | w1c_i[LINES-1:0] | (ack_i & ~edge_i);
    pend_d = set_v | (pend_q & ~clr_v);
    tmo_d  = tmo_i | (tmo_q & ~w1c_i[STAT_W-1:TMO_LSB]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      pend_q <= '0;
      tmo_q  <= '0;
    end else begin
      line_q <= line_i;
      pend_q <= pend_d;
      tmo_q  <= tmo_d;
    end
  end

  assign edge_new_o = |(set_v & ~pend_q & edge_i);
  assign status_o   = {tmo_q, {NSLOT{1'b0}}, pend_q};
endmodule

// File: rtl/aggr_irq_out.sv
module aggr_irq_out #(
  parameter int unsigned LINES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] pend_i,
  input  logic [LINES-1:0] edge_i,
  input  logic             edge_new_i,
  output logic             level_o,
  output logic             pulse_o,
  output logic             irq_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= edge_new_i;
  end

  assign level_o = |(pend_i & ~edge_i);
  assign pulse_o = pulse_q;
  assign irq_o   = level_o ^ pulse_q;
endmodule

// File: rtl/slot_irq_aggregator.sv
module slot_irq_aggregator
  import aggr_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 16,
  parameter int unsigned OFS_W  = 6,
  localparam int unsigned LINES   = 2 * NSLOT,
  localparam int unsigned TMO_LSB = LINES + NSLOT,
  localparam int unsigned STAT_W  = TMO_LSB + NSLOT,
  localparam int unsigned SW      = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  input  logic [NSLOT-1:0] tmo_i,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             ack_req_i,
  input  logic [SW-1:0]    ack_slot_i,
  input  logic [OFS_W-1:0] ack_ofs_i,
  output logic             irq_o
);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);

  logic                  wr, rd, stat_wr;
  logic [NSLOT-1:0][7:0] ctrl;
  logic [LINES-1:0]      en, edge_m, ack;
  logic [STAT_W-1:0]     status, w1c;
  logic                  edge_new, level_any, pulse;
  logic [DW-1:0]         rd_d, rdata_q;

  assign wr      = reg_req_i & reg_we_i;
  assign rd      = reg_req_i & ~reg_we_i;
  assign stat_wr = wr && (reg_addr_i == A_STAT);
  assign w1c     = stat_wr ? reg_wdata_i[STAT_W-1:0] : '0;

  for (genvar l = 0; l < LINES; l++) begin : g_ack
    assign ack[l] = ack_req_i && (ack_slot_i == SW'(l / 2))
                    && (ack_ofs_i == OFS_W'((l % 2) * 2));
  end

  aggr_ctrl_regs #(.NSLOT(NSLOT), .AW(AW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i[7:0]),
    .ctrl_o  (ctrl),
    .en_o    (en),
    .edge_o  (edge_m)
  );

  aggr_pending #(.NSLOT(NSLOT)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .tmo_i      (tmo_i),
    .en_i       (en),
    .edge_i     (edge_m),
    .w1c_i      (w1c),
    .ack_i      (ack),
    .status_o   (status),
    .edge_new_o (edge_new)
  );

  aggr_irq_out #(.LINES(LINES)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (status[LINES-1:0]),
    .edge_i     (edge_m),
    .edge_new_i (edge_new),
    .level_o    (level_any),
    .pulse_o    (pulse),
    .irq_o      (irq_o)
  );

  // revision, reset and unmapped offsets fall through to zero
  always_comb begin
    rd_d = '0;
    if (reg_addr_i == A_STAT) rd_d = DW'(status);
    for (int s = 0; s < NSLOT; s++) begin
      if (reg_addr_i == AW'(OFS_CTRL0 + 2 * s)) rd_d = DW'(ctrl[s]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_d;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/aggr_chk.sv
module aggr_chk #(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned LINES   = 2 * NSLOT,
  localparam int unsigned TMO_LSB = LINES + NSLOT,
  localparam int unsigned STAT_W  = TMO_LSB + NSLOT
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr,
  input logic [NSLOT-1:0][7:0] ctrl,
  input logic [LINES-1:0]      en,
  input logic [LINES-1:0]      edge_m,
  input logic [STAT_W-1:0]     status,
  input logic [NSLOT-1:0]      tmo_i,
  input logic                  pulse,
  input logic                  irq_o
);
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(ctrl)); // R2

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status[LINES-1:0] & ~$past(en) & ~$past(status[LINES-1:0])) == '0)); // R4

  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse && |(status[LINES-1:0] & ~edge_m)) |-> irq_o); // R6

  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[TMO_LSB-1:LINES] == '0); // R8

  AST_TMO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |tmo_i |=> (($past(tmo_i) & ~status[STAT_W-1:TMO_LSB]) == '0)); // R10
endmodule

bind slot_irq_aggregator aggr_chk #(.NSLOT(NSLOT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr     (wr),
  .ctrl   (ctrl),
  .en     (en),
  .edge_m (edge_m),
  .status (status),
  .tmo_i  (tmo_i),
  .pulse  (pulse),
  .irq_o  (irq_o)
);

// File: tb/slot_irq_aggregator_bench.sv
module slot_irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  line = '0;
  logic [3:0]  tmo = '0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        ack_req = 0;
  logic [1:0]  ack_slot = '0;
  logic [5:0]  ack_ofs = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_irq_aggregator u_slot_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .tmo_i(tmo),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ack_req_i(ack_req), .ack_slot_i(ack_slot),
    .ack_ofs_i(ack_ofs), .irq_o(irq)
  );

  task automatic chk(string req_id, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req_id, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(8'(2 + 2*s), v); chk("R1 ctrl", v, 16'h0);
    end
    rd(8'h0C, v); chk("R1 status", v, 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_ctrl();
    logic [15:0] v;
    wr(8'h04, 16'h1A5);
    rd(8'h04, v); chk("R2 slot1", v, 16'h00A5);
    wr(8'h02, 16'h3C); wr(8'h06, 16'h0F); wr(8'h08, 16'h81);
    rd(8'h02, v); chk("R2 slot0", v, 16'h003C);
    rd(8'h06, v); chk("R2 slot2", v, 16'h000F);
    rd(8'h08, v); chk("R2 slot3", v, 16'h0081);
    for (int s = 0; s < 4; s++) wr(8'(2 + 2*s), 16'h0);
  endtask

  task automatic t_fixed();
    logic [15:0] v;
    wr(8'h00, 16'hFFFF); wr(8'h0A, 16'hFFFF); wr(8'h10, 16'hFFFF);
    rd(8'h00, v); chk("R3 rev", v, 16'h0);
    rd(8'h0A, v); chk("R3 rst", v, 16'h0);
    rd(8'h10, v); chk("R3 unmapped", v, 16'h0);
    rd(8'h02, v); chk("R3 ctrl untouched", v, 16'h0);
  endtask

  task automatic t_disabled();
    logic [15:0] v;
    wr(8'h02, 16'h0080);          // slot0: only line1 enabled
    line[0] = 1; step(); step();
    chk("R4 irq", 16'(irq), 16'h0);
    rd(8'h0C, v); chk("R4 status", v, 16'h0);
    line[0] = 0; wr(8'h02, 16'h0);
  endtask

  task automatic t_level();
    logic [15:0] v;
    wr(8'h06, 16'h0080);          // slot2 line1 level
    line[5] = 1; step();
    chk("R6 irq high", 16'(irq), 16'h1);
    rd(8'h0C, v); chk("R5 set", v, 16'h0020);
    step(); chk("R6 irq held", 16'(irq), 16'h1);
    line[5] = 0; step();
    chk("R6 irq low", 16'(irq), 16'h0);
    rd(8'h0C, v); chk("R5 fall clears", v, 16'h0);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    line[5] = 1; step();
    wr(8'h0C, 16'h0F00);
    rd(8'h0C, v); chk("R8 err write ignored", v, 16'h0020);
    wr(8'h0C, 16'h0000);
    rd(8'h0C, v); chk("R8 zero write keeps", v, 16'h0020);
    wr(8'h0C, 16'h0020);
    rd(8'h0C, v); chk("R8 w1c", v, 16'h0);
    chk("R8 irq after w1c", 16'(irq), 16'h0);
    line[5] = 0; step();
  endtask

  task automatic t_ack();
    logic [15:0] v;
    line[5] = 1; step();
    @(negedge clk); ack_req = 1; ack_slot = 2; ack_ofs = 0;
    @(negedge clk); ack_req = 0;
    rd(8'h0C, v); chk("R9 wrong offset", v, 16'h0020);
    @(negedge clk); ack_req = 1; ack_slot = 1; ack_ofs = 2;
    @(negedge clk); ack_req = 0;
    rd(8'h0C, v); chk("R9 wrong slot", v, 16'h0020);
    @(negedge clk); ack_req = 1; ack_slot = 2; ack_ofs = 2;
    @(negedge clk); ack_req = 0;
    chk("R9 irq dropped", 16'(irq), 16'h0);
    rd(8'h0C, v); chk("R9 ack clears", v, 16'h0);
    line[5] = 0; step();
  endtask

  task automatic t_edge();
    logic [15:0] v;
    wr(8'h08, 16'h0050);          // slot3 line0 enabled, edge mode
    line[6] = 1; step();
    chk("R7 pulse", 16'(irq), 16'h1);
    step(); chk("R7 pulse ends", 16'(irq), 16'h0);
    rd(8'h0C, v); chk("R7 status", v, 16'h0040);
    @(negedge clk); ack_req = 1; ack_slot = 3; ack_ofs = 0;
    @(negedge clk); ack_req = 0;
    rd(8'h0C, v); chk("R9 edge not acked", v, 16'h0040);
    line[6] = 0; step();
    line[5] = 1; step();          // level source held
    chk("R6 level", 16'(irq), 16'h1);
    line[6] = 1; step();
    chk("R7 inverted", 16'(irq), 16'h0);
    step(); chk("R7 restored", 16'(irq), 16'h1);
    line[5] = 0; line[6] = 0; step();
    wr(8'h0C, 16'h00FF);
  endtask

  task automatic t_tmo();
    logic [15:0] v;
    @(negedge clk); tmo[1] = 1;
    @(negedge clk); tmo[1] = 0;
    rd(8'h0C, v); chk("R10 tmo set", v, 16'h2000);
    @(negedge clk); tmo[2] = 1; req = 1; we = 1; addr = 8'h0C; wdata = 16'h6000;
    @(negedge clk); tmo[2] = 0; req = 0; we = 0;
    rd(8'h0C, v); chk("R10 set wins", v, 16'h4000);
    wr(8'h0C, 16'h4000);
    rd(8'h0C, v); chk("R8 tmo w1c", v, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_ctrl(); t_fixed(); t_disabled(); t_level();
    t_w1c(); t_ack(); t_edge(); t_tmo();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule